// File: doc/BRIEF.md
# Pitch-Linear Copy Address Generator

This block sits at the front of a memory-to-memory copy engine and works out where each burst should read from, where it should write to, and how long it is. Software programs it with a stream of method/argument pairs. Each pair names a register offset and gives a 32-bit value. Writing to the launch offset starts a transfer. The launch argument selects the kind of transfer:

- A plain 1D copy becomes a single request of `XCount` bytes, from the source base to the destination base.
- A 2D copy where both sides are pitch-linear becomes one request per row. Each row steps forward by that side's pitch.

Requests leave on a valid/ready port. Each request carries a 64-bit source byte address, a 64-bit destination byte address and a 32-bit length. Moving the data, translating addresses and swizzling tiled surfaces are left to other blocks. When a tiled layout is requested, the generator only records that fact and reports the tile block height for each side.

Top module: `copy_addr_gen`

Register offsets, as 12-bit methods:

| Offset | Contents |
|---|---|
| 0x0C0 | launch |
| 0x100 / 0x101 | source base, upper / lower 32 bits |
| 0x102 / 0x103 | destination base, upper / lower 32 bits |
| 0x104 | source pitch |
| 0x105 | destination pitch |
| 0x106 | XCount |
| 0x107 | YCount |
| 0x108 | format |
| 0x109 | source tile dimension |
| 0x10A | source start position |
| 0x10B | destination tile dimension |
| 0x10C | destination start position |

Launch argument bits:

| Bit | Meaning when set |
|---|---|
| 7 | source is pitch-linear |
| 8 | destination is pitch-linear |
| 9 | 2D copy |

## Requirements
- R1: A command whose method is not 0x0C0 writes its argument into the register at that offset and starts nothing. A 64-bit base is built with the lower-numbered register as bits [63:32] and the next register as bits [31:0].
- R2: A launch with bit 9 clear produces exactly one request, in the cycle after the launch. That request has source = source base, destination = destination base and length = XCount.
- R3: A launch with bits 7, 8 and 9 all set produces YCount requests. Row n has source = source base + zero-extended 32-bit (n × source pitch) and destination = destination base + zero-extended 32-bit (n × destination pitch). Every row has length XCount × (format[22:20] + 1), truncated to 32 bits.
- R4: In a pitch-linear 2D copy the start-position registers (0x10A, 0x10C; X in [15:0], Y in [31:16]) have no effect, and row 0 starts exactly at the base.
- R5: While `req_valid` is high and `req_ready` is low, the request fields hold steady. The next row appears in the cycle after an acceptance. `busy` is high from the cycle after launch until the cycle after the final acceptance.
- R6: A launch while `busy` is high is dropped without disturbing the transfer in flight, and sets `launch_err`. `launch_err` then stays set until reset.
- R7: A 2D launch with bit 7 or bit 8 clear issues no request. It sets `done_status` to 1 and sets `src_tiled` / `dst_tiled` to the inverse of bits 7 / 8. This case takes priority over R8.
- R8: A 2D launch with both sides linear but XCount or YCount equal to zero issues no request and sets `done_status` to 2. Any launch that issues requests sets `done_status` to 0.
- R9: At each accepted launch, `src_blk_h` / `dst_blk_h` become 1 shifted left by bits [7:4] of the tile-dimension register for that side.
- R10: After reset there are no requests, `busy` and `launch_err` are low, `done_status` is 0, the tiled flags are low, both block heights are 1, and every register is 0.
- R11: Bases, pitches and length are captured at launch. Register writes made while busy affect only later launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_valid | input | 1 | a method/argument pair is present this cycle |
| cmd_method | input | METHOD_W | register offset or launch method |
| cmd_arg | input | 32 | argument value |
| req_valid | output | 1 | a copy request is offered |
| req_ready | input | 1 | downstream accepts the request |
| req_src | output | 64 | source byte address |
| req_dst | output | 64 | destination byte address |
| req_len | output | 32 | byte count |
| busy | output | 1 | transfer in progress |
| launch_err | output | 1 | sticky: a launch arrived while busy |
| done_status | output | 2 | 0 issued, 1 tiled skip, 2 empty skip |
| src_tiled | output | 1 | last launch asked for a tiled source |
| dst_tiled | output | 1 | last launch asked for a tiled destination |
| src_blk_h | output | 16 | source tile block height |
| dst_blk_h | output | 16 | destination tile block height |

## Verification
The properties assume that at most one command arrives per cycle and that `req_ready` is a plain level. No property depends on the downstream eventually accepting a request.

The bench keeps to these assumptions:
- It issues each command for exactly one cycle.
- It toggles `req_ready` pseudo-randomly during the multi-row copy.
- It keeps YCount small, so that every transfer drains.

The stimulus is chosen to stress the addressing:
- A lower base word near the 32-bit limit forces a carry into the upper word.
- A pitch of half the 32-bit range makes row offsets wrap.
- Nonzero start positions check that they are ignored.
- A launch is sent mid-transfer to exercise the error path.

// File: rtl/copy_addr_pkg.sv
package copy_addr_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned BLK_H_W = 16;
  localparam int unsigned CPP_W   = 3;
  localparam int unsigned DIM_W   = 4;

  // method offsets
  localparam int unsigned OFS_LAUNCH    = 'h0C0;
  localparam int unsigned OFS_SRC_HI    = 'h100;
  localparam int unsigned OFS_SRC_LO    = 'h101;
  localparam int unsigned OFS_DST_HI    = 'h102;
  localparam int unsigned OFS_DST_LO    = 'h103;
  localparam int unsigned OFS_SRC_PITCH = 'h104;
  localparam int unsigned OFS_DST_PITCH = 'h105;
  localparam int unsigned OFS_XCOUNT    = 'h106;
  localparam int unsigned OFS_YCOUNT    = 'h107;
  localparam int unsigned OFS_FORMAT    = 'h108;
  localparam int unsigned OFS_SRC_DIM   = 'h109;
  localparam int unsigned OFS_SRC_POS   = 'h10A;
  localparam int unsigned OFS_DST_DIM   = 'h10B;
  localparam int unsigned OFS_DST_POS   = 'h10C;

  // launch argument bits
  localparam int unsigned CTL_SRC_LIN = 7;
  localparam int unsigned CTL_DST_LIN = 8;
  localparam int unsigned CTL_2D      = 9;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_TILED  = 2'd1,
    ST_EMPTY  = 2'd2
  } xfer_status_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;
    logic [WORD_W-1:0] src_pitch;
    logic [WORD_W-1:0] dst_pitch;
    logic [WORD_W-1:0] x_count;
    logic [WORD_W-1:0] y_count;
    logic [CPP_W-1:0]  src_cpp_m1;
    logic [DIM_W-1:0]  src_dim;
    logic [DIM_W-1:0]  dst_dim;
  } copy_cfg_t;

endpackage

// File: rtl/copy_cfg_regs.sv
module copy_cfg_regs
  import copy_addr_pkg::*;
#(
  parameter int unsigned METHOD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [METHOD_W-1:0] wr_method,
  input  logic [WORD_W-1:0]   wr_data,
  output copy_cfg_t           cfg
);

  // Only fields the generator consumes are kept; other offsets are dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wr_method)
        METHOD_W'(OFS_SRC_HI):    cfg.src_base[ADDR_W-1:WORD_W] <= wr_data;
        METHOD_W'(OFS_SRC_LO):    cfg.src_base[WORD_W-1:0]      <= wr_data;
        METHOD_W'(OFS_DST_HI):    cfg.dst_base[ADDR_W-1:WORD_W] <= wr_data;
        METHOD_W'(OFS_DST_LO):    cfg.dst_base[WORD_W-1:0]      <= wr_data;
        METHOD_W'(OFS_SRC_PITCH): cfg.src_pitch                 <= wr_data;
        METHOD_W'(OFS_DST_PITCH): cfg.dst_pitch                 <= wr_data;
        METHOD_W'(OFS_XCOUNT):    cfg.x_count                   <= wr_data;
        METHOD_W'(OFS_YCOUNT):    cfg.y_count                   <= wr_data;
        METHOD_W'(OFS_FORMAT):    cfg.src_cpp_m1                <= wr_data[22:20];
        METHOD_W'(OFS_SRC_DIM):   cfg.src_dim                   <= wr_data[7:4];
        METHOD_W'(OFS_DST_DIM):   cfg.dst_dim                   <= wr_data[7:4];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/copy_launch_ctl.sv
module copy_launch_ctl
  import copy_addr_pkg::*;
#(
  parameter int unsigned METHOD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [METHOD_W-1:0] cmd_method,
  input  logic                busy,
  output logic                go,
  output logic                reg_wr,
  output logic                launch_err
);

  logic hit;

  assign hit    = cmd_valid && (cmd_method == METHOD_W'(OFS_LAUNCH));
  assign go     = hit && !busy;
  assign reg_wr = cmd_valid && !hit;

  always_ff @(posedge clk) begin
    if (rst)            launch_err <= 1'b0;
    else if (hit && busy) launch_err <= 1'b1;
  end

endmodule

// File: rtl/copy_row_seq.sv
module copy_row_seq
  import copy_addr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               lin_s,
  input  logic               lin_d,
  input  logic               mode_2d,
  input  copy_cfg_t          cfg,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_src,
  output logic [ADDR_W-1:0]  req_dst,
  output logic [WORD_W-1:0]  req_len,
  output xfer_status_e       status,
  output logic               src_tiled,
  output logic               dst_tiled,
  output logic [BLK_H_W-1:0] src_blk_h,
  output logic [BLK_H_W-1:0] dst_blk_h
);

  logic [ADDR_W-1:0] src_base_q, dst_base_q;
  logic [WORD_W-1:0] src_pitch_q, dst_pitch_q;
  logic [WORD_W-1:0] src_off, dst_off, src_nxt, dst_nxt;
  logic [WORD_W-1:0] rows_left, row_len;

  assign row_len = cfg.x_count * WORD_W'({1'b0, cfg.src_cpp_m1} + 4'd1);
  assign src_nxt = src_off + src_pitch_q;
  assign dst_nxt = dst_off + dst_pitch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_src     <= '0;
      req_dst     <= '0;
      req_len     <= '0;
      status      <= ST_ISSUED;
      src_tiled   <= 1'b0;
      dst_tiled   <= 1'b0;
      src_blk_h   <= BLK_H_W'(1);
      dst_blk_h   <= BLK_H_W'(1);
      src_base_q  <= '0;
      dst_base_q  <= '0;
      src_pitch_q <= '0;
      dst_pitch_q <= '0;
      src_off     <= '0;
      dst_off     <= '0;
      rows_left   <= '0;
    end else if (go) begin
      src_base_q  <= cfg.src_base;
      dst_base_q  <= cfg.dst_base;
      src_pitch_q <= cfg.src_pitch;
      dst_pitch_q <= cfg.dst_pitch;
      src_off     <= '0;
      dst_off     <= '0;
      src_tiled   <= !lin_s;
      dst_tiled   <= !lin_d;
      src_blk_h   <= BLK_H_W'(1) << cfg.src_dim;
      dst_blk_h   <= BLK_H_W'(1) << cfg.dst_dim;
      if (!mode_2d) begin
        req_valid <= 1'b1;
        rows_left <= WORD_W'(1);
        req_src   <= cfg.src_base;
        req_dst   <= cfg.dst_base;
        req_len   <= cfg.x_count;
        status    <= ST_ISSUED;
      end else if (!(lin_s && lin_d)) begin
        status    <= ST_TILED;
      end else if (cfg.x_count == '0 || cfg.y_count == '0) begin
        status    <= ST_EMPTY;
      end else begin
        req_valid <= 1'b1;
        rows_left <= cfg.y_count;
        req_src   <= cfg.src_base;
        req_dst   <= cfg.dst_base;
        req_len   <= row_len;
        status    <= ST_ISSUED;
      end
    end else if (req_valid && req_ready) begin
      if (rows_left == WORD_W'(1)) begin
        req_valid <= 1'b0;
        rows_left <= '0;
      end else begin
        rows_left <= rows_left - WORD_W'(1);
        src_off   <= src_nxt;
        dst_off   <= dst_nxt;
        req_src   <= src_base_q + {{(ADDR_W-WORD_W){1'b0}}, src_nxt};
        req_dst   <= dst_base_q + {{(ADDR_W-WORD_W){1'b0}}, dst_nxt};
      end
    end
  end

endmodule

// File: rtl/copy_addr_gen.sv
module copy_addr_gen
  import copy_addr_pkg::*;
#(
  parameter int unsigned METHOD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [METHOD_W-1:0] cmd_method,
  input  logic [31:0]         cmd_arg,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [63:0]         req_src,
  output logic [63:0]         req_dst,
  output logic [31:0]         req_len,
  output logic                busy,
  output logic                launch_err,
  output logic [1:0]          done_status,
  output logic                src_tiled,
  output logic                dst_tiled,
  output logic [15:0]         src_blk_h,
  output logic [15:0]         dst_blk_h
);

  copy_cfg_t    cfg;
  logic         go, reg_wr;
  xfer_status_e status;

  assign busy        = req_valid;
  assign done_status = status;

  copy_launch_ctl #(.METHOD_W(METHOD_W)) u_launch (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_method (cmd_method),
    .busy       (busy),
    .go         (go),
    .reg_wr     (reg_wr),
    .launch_err (launch_err)
  );

  copy_cfg_regs #(.METHOD_W(METHOD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_method (cmd_method),
    .wr_data   (cmd_arg),
    .cfg       (cfg)
  );

  copy_row_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .lin_s     (cmd_arg[CTL_SRC_LIN]),
    .lin_d     (cmd_arg[CTL_DST_LIN]),
    .mode_2d   (cmd_arg[CTL_2D]),
    .cfg       (cfg),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_dst   (req_dst),
    .req_len   (req_len),
    .status    (status),
    .src_tiled (src_tiled),
    .dst_tiled (dst_tiled),
    .src_blk_h (src_blk_h),
    .dst_blk_h (dst_blk_h)
  );

endmodule

// File: rtl/copy_addr_gen_chk.sv
module copy_addr_gen_chk
  import copy_addr_pkg::*;
#(
  parameter int unsigned METHOD_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [METHOD_W-1:0] cmd_method,
  input logic [31:0]         cmd_arg,
  input logic                req_valid,
  input logic                req_ready,
  input logic [63:0]         req_src,
  input logic [63:0]         req_dst,
  input logic [31:0]         req_len,
  input logic                busy,
  input logic                launch_err,
  input logic [1:0]          done_status,
  input logic                src_tiled,
  input logic                dst_tiled,
  input logic [15:0]         src_blk_h,
  input logic [15:0]         dst_blk_h
);

  logic launch_cmd;
  assign launch_cmd = cmd_valid && (cmd_method == METHOD_W'(OFS_LAUNCH));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    launch_err |=> launch_err);

  // R6
  busy_launch_err_chk: assert property (@(posedge clk) disable iff (rst)
    launch_cmd && busy |=> launch_err);

  // R2
  one_d_start_chk: assert property (@(posedge clk) disable iff (rst)
    launch_cmd && !busy && !cmd_arg[CTL_2D] |=> req_valid && busy);

  // R7
  tiled_skip_chk: assert property (@(posedge clk) disable iff (rst)
    launch_cmd && !busy && cmd_arg[CTL_2D] && !(cmd_arg[CTL_SRC_LIN] && cmd_arg[CTL_DST_LIN])
    |=> !req_valid && done_status == 2'd1);

  // R9
  blk_h_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(src_blk_h) && $onehot(dst_blk_h));

endmodule

bind copy_addr_gen copy_addr_gen_chk #(.METHOD_W(METHOD_W)) u_chk (.*);

// File: tb/copy_addr_gen_tb.sv
module copy_addr_gen_tb;
  import copy_addr_pkg::*;

  localparam int MW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [MW-1:0] cmd_method = '0;
  logic [31:0]   cmd_arg = '0;
  logic          req_valid, req_ready = 1'b1;
  logic [63:0]   req_src, req_dst;
  logic [31:0]   req_len;
  logic          busy, launch_err, src_tiled, dst_tiled;
  logic [1:0]    done_status;
  logic [15:0]   src_blk_h, dst_blk_h;

  copy_addr_gen #(.METHOD_W(MW)) u_dut (.*);

  typedef struct packed { logic [63:0] s; logic [63:0] d; logic [31:0] l; } req_t;

  req_t         exp_q[$];
  logic [31:0]  mreg [int];
  bit           m_err, m_stile, m_dtile, was_busy, run_cmp, rdy_rand;
  logic [1:0]   m_status;
  logic [15:0]  m_sblk, m_dblk;
  int           tests, fails;
  string        cur_tag = "R1";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(int k);
    return mreg.exists(k) ? mreg[k] : 32'h0;
  endfunction

  task automatic model_launch(logic [31:0] a);
    logic [63:0] sb, db;
    logic [31:0] x, y, sp, dp, so, dof, len;
    sb = {rd(OFS_SRC_HI), rd(OFS_SRC_LO)};
    db = {rd(OFS_DST_HI), rd(OFS_DST_LO)};
    x = rd(OFS_XCOUNT); y = rd(OFS_YCOUNT);
    sp = rd(OFS_SRC_PITCH); dp = rd(OFS_DST_PITCH);
    len = x * (((rd(OFS_FORMAT) >> 20) & 32'h7) + 32'd1);
    m_stile = !a[7]; m_dtile = !a[8];
    m_sblk = 16'(1) << ((rd(OFS_SRC_DIM) >> 4) & 32'hF);
    m_dblk = 16'(1) << ((rd(OFS_DST_DIM) >> 4) & 32'hF);
    if (!a[9]) begin
      exp_q.push_back('{sb, db, x});
      m_status = 2'd0;
    end else if (!(a[7] && a[8])) begin
      m_status = 2'd1;
    end else if (x == 0 || y == 0) begin
      m_status = 2'd2;
    end else begin
      for (int r = 0; r < int'(y); r++) begin
        so  = sp * 32'(r);
        dof = dp * 32'(r);
        exp_q.push_back('{sb + {32'h0, so}, db + {32'h0, dof}, len});
      end
      m_status = 2'd0;
    end
  endtask

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete(); mreg.delete();
      m_err = 0; m_status = 2'd0; m_stile = 0; m_dtile = 0;
      m_sblk = 16'd1; m_dblk = 16'd1;
    end else begin
      was_busy = exp_q.size() > 0;
      if (was_busy && req_ready) void'(exp_q.pop_front());
      if (cmd_valid) begin
        if (cmd_method == MW'(OFS_LAUNCH)) begin
          if (was_busy) m_err = 1;
          else model_launch(cmd_arg);
        end else begin
          mreg[int'(cmd_method)] = cmd_arg;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && run_cmp) begin
      chk("R5", "req_valid", 64'(req_valid), 64'(exp_q.size() > 0));
      chk("R5", "busy", 64'(busy), 64'(exp_q.size() > 0));
      if (exp_q.size() > 0 && req_valid) begin
        chk(cur_tag, "req_src", req_src, exp_q[0].s);
        chk(cur_tag, "req_dst", req_dst, exp_q[0].d);
        chk(cur_tag, "req_len", 64'(req_len), 64'(exp_q[0].l));
      end
      chk("R6", "launch_err", 64'(launch_err), 64'(m_err));
      chk("R8", "done_status", 64'(done_status), 64'(m_status));
      chk("R7", "src_tiled", 64'(src_tiled), 64'(m_stile));
      chk("R7", "dst_tiled", 64'(dst_tiled), 64'(m_dtile));
      chk("R9", "src_blk_h", 64'(src_blk_h), 64'(m_sblk));
      chk("R9", "dst_blk_h", 64'(dst_blk_h), 64'(m_dblk));
    end
  end

  always @(negedge clk) req_ready <= rdy_rand ? ($urandom % 3 != 0) : 1'b1;

  task automatic cmd(int m, logic [31:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_method = MW'(m); cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && (req_valid || exp_q.size() > 0); i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R5 watchdog act=hung exp=idle");
    finish_run();
  end

  initial begin
    rdy_rand = 0; run_cmp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset req_valid", 64'(req_valid), 64'd0);
    chk("R10", "reset busy", 64'(busy), 64'd0);
    chk("R10", "reset err", 64'(launch_err), 64'd0);
    chk("R10", "reset status", 64'(done_status), 64'd0);
    chk("R10", "reset blk_h", 64'({src_blk_h, dst_blk_h}), 64'h0001_0001);
    run_cmp = 1;

    // R1 / R2: 1D copy
    cur_tag = "R2";
    cmd(OFS_SRC_HI, 32'h0000_0001); cmd(OFS_SRC_LO, 32'h2000_0000);
    cmd(OFS_DST_HI, 32'h0000_000A); cmd(OFS_DST_LO, 32'h0000_0040);
    cmd(OFS_XCOUNT, 32'h123);
    cmd(OFS_LAUNCH, 32'h0);
    chk("R2", "1D valid after launch", 64'(req_valid), 64'd1);
    chk("R1", "1D src base order", req_src, 64'h0000_0001_2000_0000);
    wait_idle();

    // R3 / R4 / R11: 2D linear with carry and wrap, stalling ready
    cur_tag = "R3";
    cmd(OFS_SRC_POS, 32'h0007_0003); cmd(OFS_DST_POS, 32'h0002_0009);
    cmd(OFS_SRC_LO, 32'hFFFF_FFF0); cmd(OFS_SRC_PITCH, 32'h8000_0010);
    cmd(OFS_DST_PITCH, 32'h0000_0100);
    cmd(OFS_FORMAT, 32'h0530_0000); cmd(OFS_XCOUNT, 32'd5); cmd(OFS_YCOUNT, 32'd5);
    rdy_rand = 1;
    cmd(OFS_LAUNCH, 32'h380);
    chk("R4", "row0 src at base", req_src, 64'h0000_0001_FFFF_FFF0);
    chk("R4", "row0 dst at base", req_dst, 64'h0000_000A_0000_0040);
    chk("R3", "row len", 64'(req_len), 64'd20);
    cmd(OFS_SRC_PITCH, 32'h4);          // R11: no effect on rows in flight
    cmd(OFS_LAUNCH, 32'h0);             // R6: dropped
    chk("R6", "err after busy launch", 64'(launch_err), 64'd1);
    wait_idle();
    rdy_rand = 0;
    cmd(OFS_SRC_PITCH, 32'h8000_0010);

    // R7 / R9: tiled source
    cur_tag = "R7";
    cmd(OFS_SRC_DIM, 32'h0000_0030); cmd(OFS_DST_DIM, 32'h0000_00A0);
    cmd(OFS_LAUNCH, 32'h300);
    chk("R7", "tiled status", 64'(done_status), 64'd1);
    chk("R7", "tiled no request", 64'(req_valid), 64'd0);
    chk("R9", "blk heights", 64'({src_blk_h, dst_blk_h}), 64'h0008_0400);
    cmd(OFS_XCOUNT, 32'd0);
    cmd(OFS_LAUNCH, 32'h280);           // tiled wins over empty
    chk("R7", "tiled priority", 64'(done_status), 64'd1);

    // R8: empty 2D
    cur_tag = "R8";
    cmd(OFS_LAUNCH, 32'h380);
    chk("R8", "x zero status", 64'(done_status), 64'd2);
    cmd(OFS_XCOUNT, 32'd3); cmd(OFS_YCOUNT, 32'd0);
    cmd(OFS_LAUNCH, 32'h380);
    chk("R8", "y zero status", 64'(done_status), 64'd2);
    cmd(OFS_YCOUNT, 32'd2);
    cmd(OFS_LAUNCH, 32'h380);
    chk("R8", "issued status", 64'(done_status), 64'd0);
    wait_idle();

    // R2: 1D with zero length still issues one request
    cur_tag = "R2";
    cmd(OFS_XCOUNT, 32'd0);
    cmd(OFS_LAUNCH, 32'h0);
    chk("R2", "1D zero len", 64'({req_valid, req_len}), 64'h1_0000_0000);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule